// File: doc/BRIEF.md
# Mode-Switchable Flat Address Generator

This block forms the memory address for a core that executes a 16-bit-operand instruction set. It works in one of two modes. In segmented mode the address is the segment value shifted left by four plus a 16-bit offset. In flat mode the address is the full 32-bit sum of the register operands, and the segment registers take no part. The mode comes from bit 0 of the per-process translation-control word, so each context switch can change it.

Each request carries the base, index and displacement values, the stack and instruction pointers, the selected segment value, a segment-override flag, an operand-width flag and an operation class. One cycle after a request, the block returns the address together with an invalid-opcode flag. In flat mode, segment overrides and far transfers are rejected. A dedicated flat-load class, which also serves address-only computation, always produces a flat 32-bit address in either mode.

Top module: `flat_agu`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `fault_ud` and `addr_out` become 0 at that edge.
- R2: A request presented with `in_valid` high at a clock edge produces `out_valid` high after that edge, with its result. An edge with `in_valid` low leaves `out_valid` low.
- R3: Flat mode is selected by bit 0 of `ctx_ctrl` (1 means flat). Every other bit of `ctx_ctrl` has no effect on the result.
- R4: In segmented mode, class MEM (code 0) yields `(seg_val*16 + ((base_val+index_val+disp_val) mod 2^16)) mod 2^20`, zero-extended to 32 bits. Bits 31:20 of the address are 0.
- R5: In flat mode, class MEM yields `(base_val+index_val+disp_val) mod 2^32`. `seg_val` has no effect.
- R6: In flat mode, any request with `seg_ovr` high raises `fault_ud`. Whenever `fault_ud` is high, `addr_out` is 0.
- R7: In flat mode, class FAR (code 2, a far call or far jump) raises `fault_ud`.
- R8: In flat mode, class PUSH (code 3) yields `sp_val - n`, class POP (code 4) yields `sp_val`, and class FETCH (code 5) yields `ip_val`. All three use full 32-bit values. `n` is 4 when `op_wide` is 1 and 2 when it is 0.
- R9: In segmented mode, PUSH yields `seg_val*16 + ((sp_val-n) mod 2^16)`, POP yields `seg_val*16 + (sp_val mod 2^16)`, and FETCH yields `seg_val*16 + (ip_val mod 2^16)`. All of these are taken mod 2^20.
- R10: Class FLAT (code 1) yields `(base_val+index_val+disp_val) mod 2^32` in both modes. In segmented mode it does not fault, even with `seg_ovr` high.
- R11: In segmented mode, class FAR yields `seg_val*16 + (disp_val mod 2^16)` without a fault, with or without `seg_ovr`.
- R12: Class codes 6 and 7 are reserved and raise `fault_ud` in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| ctx_ctrl | input | 32 | Per-process translation-control word; bit 0 selects flat mode |
| op_class | input | 3 | Operation class: 0 MEM, 1 FLAT, 2 FAR, 3 PUSH, 4 POP, 5 FETCH |
| seg_ovr | input | 1 | Instruction carries a segment-override prefix |
| op_wide | input | 1 | Stack operand is 4 bytes (1) or 2 bytes (0) |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| disp_val | input | 32 | Displacement |
| sp_val | input | 32 | Stack pointer |
| ip_val | input | 32 | Instruction pointer |
| seg_val | input | 16 | Selected segment register value |
| out_valid | output | 1 | Result valid |
| addr_out | output | 32 | Formed address |
| fault_ud | output | 1 | Invalid-opcode fault |

## Verification
The bench targets the two wrap points of segmented mode.

- **16-bit offset wrap.** An offset sum that crosses 0xFFFF must wrap. A design that carried into the segment part would return an address 64 KiB too high.
- **20-bit final wrap.** Segment 0xFFFF plus offset 0xFFFF must wrap to 0x0FFEF. A design without the wrap would set bit 20.
- **Segmented push from stack pointer 1.** This must wrap to offset 0xFFFF. A design that subtracted in 32 bits without masking would place the address below the segment.

The bench also covers the following mode cases:

- **Mode bit and the other `ctx_ctrl` bits.** A design that decoded the wrong bit would switch mode when unrelated bits change.
- **Flat-load class with an override in segmented mode.** This must neither fault nor apply the segment.
- **Flat mode with an override or a far transfer.** These must fault with a zero address rather than produce a usable address.

// File: rtl/flat_agu_pkg.sv
package flat_agu_pkg;
  typedef enum logic [2:0] {
    CLS_MEM   = 3'd0,
    CLS_FLAT  = 3'd1,
    CLS_FAR   = 3'd2,
    CLS_PUSH  = 3'd3,
    CLS_POP   = 3'd4,
    CLS_FETCH = 3'd5
  } op_class_e;

  localparam int CLS_W = 3;
  localparam int LAST_CLS = 5;
endpackage

// File: rtl/agu_operand_sel.sv
module agu_operand_sel
  import flat_agu_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int NARROW_BYTES = 2,
  parameter int WIDE_BYTES   = 4
) (
  input  logic [CLS_W-1:0]  op_class,
  input  logic              op_wide,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [ADDR_W-1:0] disp_val,
  input  logic [ADDR_W-1:0] sp_val,
  input  logic [ADDR_W-1:0] ip_val,
  output logic [ADDR_W-1:0] raw_ofs
);
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] ea_sum;

  always_comb begin
    step   = op_wide ? ADDR_W'(WIDE_BYTES) : ADDR_W'(NARROW_BYTES);
    ea_sum = base_val + index_val + disp_val;
    case (op_class)
      CLS_MEM, CLS_FLAT: raw_ofs = ea_sum;
      CLS_FAR:           raw_ofs = disp_val;
      CLS_PUSH:          raw_ofs = sp_val - step;
      CLS_POP:           raw_ofs = sp_val;
      CLS_FETCH:         raw_ofs = ip_val;
      default:           raw_ofs = '0;
    endcase
  end
endmodule

// File: rtl/agu_seg_map.sv
module agu_seg_map #(
  parameter int ADDR_W    = 32,
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic [SEG_W-1:0]  seg_val,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] seg_addr
);
  localparam int PHYS_W = SEG_W + SEG_SHIFT;

  logic [PHYS_W-1:0] phys;

  always_comb begin
    phys     = {seg_val, {SEG_SHIFT{1'b0}}} + PHYS_W'(ofs);
    seg_addr = {{(ADDR_W-PHYS_W){1'b0}}, phys};
  end
endmodule

// File: rtl/agu_fault_chk.sv
module agu_fault_chk
  import flat_agu_pkg::*;
(
  input  logic             flat_mode,
  input  logic             seg_ovr,
  input  logic [CLS_W-1:0] op_class,
  output logic             fault
);
  logic reserved;
  logic is_far;

  always_comb begin
    reserved = int'(op_class) > LAST_CLS;
    is_far   = op_class == CLS_FAR;
    fault    = reserved | (flat_mode & (seg_ovr | is_far));
  end
endmodule

// File: rtl/flat_agu.sv
module flat_agu
  import flat_agu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CTRL_W    = 32,
  parameter int MODE_BIT  = 0,
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CTRL_W-1:0] ctx_ctrl,
  input  logic [2:0]        op_class,
  input  logic              seg_ovr,
  input  logic              op_wide,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [ADDR_W-1:0] disp_val,
  input  logic [ADDR_W-1:0] sp_val,
  input  logic [ADDR_W-1:0] ip_val,
  input  logic [SEG_W-1:0]  seg_val,
  output logic              out_valid,
  output logic [ADDR_W-1:0] addr_out,
  output logic              fault_ud
);
  localparam int PHYS_W = SEG_W + SEG_SHIFT;

  logic              flat_mode;
  logic              use_flat;
  logic              fault_c;
  logic [ADDR_W-1:0] raw_ofs;
  logic [ADDR_W-1:0] seg_addr;
  logic [ADDR_W-1:0] addr_c;
  logic              unused_ctx;

  assign unused_ctx = ^ctx_ctrl;
  assign flat_mode  = ctx_ctrl[MODE_BIT];
  assign use_flat   = flat_mode | (op_class == CLS_FLAT);

  agu_operand_sel #(.ADDR_W(ADDR_W)) u_sel (
    .op_class (op_class),
    .op_wide  (op_wide),
    .base_val (base_val),
    .index_val(index_val),
    .disp_val (disp_val),
    .sp_val   (sp_val),
    .ip_val   (ip_val),
    .raw_ofs  (raw_ofs)
  );

  agu_seg_map #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)
  ) u_map (
    .seg_val (seg_val),
    .ofs     (raw_ofs[OFS_W-1:0]),
    .seg_addr(seg_addr)
  );

  agu_fault_chk u_flt (
    .flat_mode(flat_mode),
    .seg_ovr  (seg_ovr),
    .op_class (op_class),
    .fault    (fault_c)
  );

  always_comb begin
    if (fault_c)       addr_c = '0;
    else if (use_flat) addr_c = raw_ofs;
    else               addr_c = seg_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      addr_out  <= '0;
      fault_ud  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        addr_out <= addr_c;
        fault_ud <= fault_c;
      end
    end
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R6
  flat_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctx_ctrl[MODE_BIT] && seg_ovr) |=> fault_ud);

  // R7
  flat_far_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctx_ctrl[MODE_BIT] && op_class == CLS_FAR) |=> fault_ud);

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && fault_ud) |-> addr_out == '0);

  // R4
  seg_range_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ctx_ctrl[MODE_BIT] && op_class == CLS_MEM)
      |=> addr_out[ADDR_W-1:PHYS_W] == '0);
endmodule

// File: tb/test_flat_agu.sv
module test_flat_agu;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] ctx_ctrl;
  logic [2:0]  op_class;
  logic        seg_ovr;
  logic        op_wide;
  logic [31:0] base_val, index_val, disp_val, sp_val, ip_val;
  logic [15:0] seg_val;
  logic        out_valid;
  logic [31:0] addr_out;
  logic        fault_ud;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  flat_agu i_flat_agu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ctx_ctrl(ctx_ctrl),
    .op_class(op_class), .seg_ovr(seg_ovr), .op_wide(op_wide),
    .base_val(base_val), .index_val(index_val), .disp_val(disp_val),
    .sp_val(sp_val), .ip_val(ip_val), .seg_val(seg_val),
    .out_valid(out_valid), .addr_out(addr_out), .fault_ud(fault_ud)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    in_valid = 0; ctx_ctrl = 0; op_class = 0; seg_ovr = 0; op_wide = 0;
    base_val = 0; index_val = 0; disp_val = 0; sp_val = 0; ip_val = 0;
    seg_val = 0;
  endtask

  // Launch one request at a falling edge; result is sampled at the next falling edge.
  task automatic issue(string req, logic [31:0] exp_addr, logic exp_flt);
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk({req, " valid"}, {31'b0, out_valid}, 32'd1);
    chk({req, " fault"}, {31'b0, fault_ud}, {31'b0, exp_flt});
    chk({req, " addr"},  addr_out, exp_addr);
    @(negedge clk);
    chk({req, " idle"},  {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_reset();
    rst = 1; clear_in();
    repeat (3) @(negedge clk);
    chk("R1 valid", {31'b0, out_valid}, 32'd0);
    chk("R1 fault", {31'b0, fault_ud}, 32'd0);
    chk("R1 addr",  addr_out, 32'd0);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_seg_mem();
    clear_in(); seg_val = 16'h1234; base_val = 32'h0001_0010;
    index_val = 32'hFFFF_0020; disp_val = 32'h5;
    issue("R4 basic", 32'h0001_2375, 0);
    clear_in(); seg_val = 16'hF000; base_val = 32'hFFF0; index_val = 32'h20;
    issue("R4 ofs wrap", 32'h000F_0010, 0);
    clear_in(); seg_val = 16'hFFFF; base_val = 32'hFFFF;
    issue("R4 20b wrap", 32'h0000_FFEF, 0);
  endtask

  task automatic t_mode_bit();
    clear_in(); ctx_ctrl = 32'hFFFF_FFFE; seg_val = 16'h1234;
    base_val = 32'h0001_0010; index_val = 32'hFFFF_0020; disp_val = 32'h5;
    issue("R3 bit0 clear", 32'h0001_2375, 0);
    ctx_ctrl = 32'h0000_1001;
    issue("R3 bit0 set", 32'h0000_0035, 0);
  endtask

  task automatic t_flat_mem();
    clear_in(); ctx_ctrl = 1; seg_val = 16'hABCD; base_val = 32'h8000_0000;
    index_val = 32'h1234_5678; disp_val = 32'hFFFF_FFFC;
    issue("R5 flat mem", 32'h9234_5674, 0);
  endtask

  task automatic t_flat_reject();
    clear_in(); ctx_ctrl = 1; base_val = 32'h100; seg_ovr = 1;
    issue("R6 override", 32'h0, 1);
    clear_in(); ctx_ctrl = 1; op_class = 3'd2; disp_val = 32'h4000;
    issue("R7 far", 32'h0, 1);
  endtask

  task automatic t_flat_stack();
    clear_in(); ctx_ctrl = 1; sp_val = 32'h0010_0000; seg_val = 16'h5555;
    op_class = 3'd3; op_wide = 1;
    issue("R8 push4", 32'h000F_FFFC, 0);
    op_wide = 0;
    issue("R8 push2", 32'h000F_FFFE, 0);
    op_class = 3'd4;
    issue("R8 pop", 32'h0010_0000, 0);
    op_class = 3'd5; ip_val = 32'h00AB_CDEF;
    issue("R8 fetch", 32'h00AB_CDEF, 0);
  endtask

  task automatic t_seg_stack();
    clear_in(); op_class = 3'd3; sp_val = 32'h1; seg_val = 16'h2000;
    issue("R9 push wrap", 32'h0002_FFFF, 0);
    op_class = 3'd4; sp_val = 32'h1234_0100; seg_val = 16'h3000;
    issue("R9 pop", 32'h0003_0100, 0);
    op_class = 3'd5; ip_val = 32'hFFFF_0042; seg_val = 16'hF000;
    issue("R9 fetch", 32'h000F_0042, 0);
  endtask

  task automatic t_flat_class();
    clear_in(); op_class = 3'd1; seg_ovr = 1; seg_val = 16'h7000;
    base_val = 32'h0002_0000; index_val = 32'h10; disp_val = 32'h4;
    issue("R10 seg mode", 32'h0002_0014, 0);
    ctx_ctrl = 1; seg_ovr = 0;
    issue("R10 flat mode", 32'h0002_0014, 0);
  endtask

  task automatic t_seg_far();
    clear_in(); op_class = 3'd2; seg_val = 16'h1000; disp_val = 32'h0001_2345;
    seg_ovr = 1;
    issue("R11 far ovr", 32'h0001_2345, 0);
    seg_ovr = 0;
    issue("R11 far", 32'h0001_2345, 0);
  endtask

  task automatic t_reserved();
    clear_in(); op_class = 3'd6; base_val = 32'h10;
    issue("R12 code6 seg", 32'h0, 1);
    ctx_ctrl = 1; op_class = 3'd7;
    issue("R12 code7 flat", 32'h0, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_seg_mem();
    t_mode_bit();
    t_flat_mem();
    t_flat_reject();
    t_flat_stack();
    t_seg_stack();
    t_flat_class();
    t_seg_far();
    t_reserved();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule